// File: doc/BRIEF.md
# Feedback Transient and Fault Supervisor

This block sits beside the gate timing estimator of a two-channel synchronous rectifier controller. It receives one digitised word per switching cycle. The word is proportional to the current in the opto-coupler diode, measured as the supply voltage minus the feedback pin voltage. From these words it raises a timed shrink request whenever the feedback current jumps upward from one cycle to the next, so that the estimator can cut the following gate pulses short during a load transient.

The block also gathers every condition that must stop the rectifier drive into a single disable output. These are: a sustained near-zero feedback word, meaning the output is shorted; the programming resistor pin being shorted low or left open, each reported by a comparator flag; supply over-voltage; and die over-temperature. Each condition has its own debounce rule and its own latching rule. Every time constant is a count of clock cycles, set by a parameter.

Top module: `fb_fault_supervisor`

## Requirements
- R1: After reset, `shrink_req` and `drive_disable` are both low.
- R2: When `fb_valid` delivers a word `cur` and the previous valid word `prv` satisfies cur×100 > prv×120, `shrink_req` goes high from the next cycle and stays high for exactly `SHRINK_TICKS` cycles. The first word after reset has no predecessor and never triggers.
- R3: A word with cur×100 ≤ prv×120, such as an exact 20 % rise or a fall, does not raise `shrink_req`.
- R4: A qualifying rise while the window is already open restarts the window, so it lasts `SHRINK_TICKS` cycles from the newest rise.
- R5: Once at least one word has been received, a latest word below `SCP_LEVEL` that remains the latest word for `SCP_TICKS` consecutive cycles sets a short fault. The fault drives `drive_disable` high and stays latched until reset. A word at or above the level resets the count.
- R6: `rp_low_flag` high for `PIN_TICKS` consecutive cycles sets a latched pin-short fault that disables the drive. A gap in the flag restarts the count.
- R7: `rp_high_flag` high for `PIN_TICKS` consecutive cycles sets a latched pin-open fault that disables the drive.
- R8: `vdd_over_flag` high for `OVP_TICKS` consecutive cycles disables the drive. The disable is released in the cycle after the flag drops, because the hysteresis lives in the comparator.
- R9: `temp_hot_flag` disables the drive from the next cycle. The disable holds until `temp_cool_flag` is seen, and the hot flag wins if both are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fb_valid | input | 1 | One-cycle strobe, once per switching cycle |
| fb_sample | input | SAMPLE_W | Supply-minus-feedback word |
| rp_low_flag | input | 1 | Programming pin below its short level |
| rp_high_flag | input | 1 | Programming pin above its open level |
| vdd_over_flag | input | 1 | Supply over-voltage comparator output |
| temp_hot_flag | input | 1 | Die above the shutdown temperature |
| temp_cool_flag | input | 1 | Die below the restart temperature |
| shrink_req | output | 1 | Feedback-transient shrink window active |
| drive_disable | output | 1 | Inhibit for both rectifier gates |

## Verification
The bench targets the ratio boundary, where an exact 20 % step must not trigger. A design that divides, rounds or uses ≥ instead of > opens spurious windows there. It checks window length to the cycle and the restart on a second rise. An off-by-one timer, or one that ignores a rise during an open window, shows up as an early drop. Debounce interruption is exercised on the short and pin paths: a qualifier that does not clear its count would trip early. The release of the over-voltage disable and the hold of the thermal disable are both tested, so a swapped latching rule is caught.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  // Upward step of more than 20 percent, without division.
  function automatic logic fb_rise(input logic [31:0] cur, input logic [31:0] prv);
    logic [39:0] lhs, rhs;
    lhs = {8'd0, cur} * 40'd100;
    rhs = {8'd0, prv} * 40'd120;
    return lhs > rhs;
  endfunction

  function automatic logic fb_below(input logic [31:0] word, input logic [31:0] level);
    return word < level;
  endfunction
endpackage

// File: rtl/debounce_qual.sv
module debounce_qual #(
  parameter int TICKS = 16,
  parameter bit LATCH = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic fault_o
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fault_o <= 1'b0;
    end else if (!flag_i) begin
      cnt_q <= '0;
      if (!LATCH) fault_o <= 1'b0;
    end else if (cnt_q == LAST) begin
      fault_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5, R6, R7, R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> $past(flag_i));

  generate
    if (LATCH) begin : g_latch
      // R5, R6, R7
      fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);
    end else begin : g_follow
      // R8
      fault_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_i |=> !fault_o);
    end
  endgenerate
endmodule

// File: rtl/shrink_timer.sv
module shrink_timer #(
  parameter int TICKS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic active_o
);
  localparam int CW = $clog2(TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign active_o = (cnt_q != '0);

  // R2, R4
  win_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> active_o);

  // R3
  win_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !active_o) |=> !active_o);
endmodule

// File: rtl/fb_fault_supervisor.sv
module fb_fault_supervisor
  import fbs_pkg::*;
#(
  parameter int SAMPLE_W     = 12,
  parameter int SCP_LEVEL    = 270,
  parameter int SHRINK_TICKS = 11250,
  parameter int SCP_TICKS    = 2000,
  parameter int PIN_TICKS    = 250,
  parameter int OVP_TICKS    = 7500
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fb_valid,
  input  logic [SAMPLE_W-1:0] fb_sample,
  input  logic                rp_low_flag,
  input  logic                rp_high_flag,
  input  logic                vdd_over_flag,
  input  logic                temp_hot_flag,
  input  logic                temp_cool_flag,
  output logic                shrink_req,
  output logic                drive_disable
);
  localparam int PADW = 32 - SAMPLE_W;

  logic [SAMPLE_W-1:0] prev_q;
  logic                have_q;
  logic                rise_evt;
  logic                scp_low;
  logic                scp_fault, pin_short_fault, pin_open_fault, ovp_fault;
  logic                otp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (fb_valid) begin
      prev_q <= fb_sample;
      have_q <= 1'b1;
    end
  end

  assign rise_evt = fb_valid && have_q &&
                    fb_rise({{PADW{1'b0}}, fb_sample}, {{PADW{1'b0}}, prev_q});
  assign scp_low  = have_q && fb_below({{PADW{1'b0}}, prev_q}, 32'(SCP_LEVEL));

  shrink_timer #(.TICKS(SHRINK_TICKS)) u_shrink (
    .clk(clk), .rst_n(rst_n), .start_i(rise_evt), .active_o(shrink_req));

  debounce_qual #(.TICKS(SCP_TICKS), .LATCH(1'b1)) u_scp (
    .clk(clk), .rst_n(rst_n), .flag_i(scp_low), .fault_o(scp_fault));
  debounce_qual #(.TICKS(PIN_TICKS), .LATCH(1'b1)) u_pin_short (
    .clk(clk), .rst_n(rst_n), .flag_i(rp_low_flag), .fault_o(pin_short_fault));
  debounce_qual #(.TICKS(PIN_TICKS), .LATCH(1'b1)) u_pin_open (
    .clk(clk), .rst_n(rst_n), .flag_i(rp_high_flag), .fault_o(pin_open_fault));
  debounce_qual #(.TICKS(OVP_TICKS), .LATCH(1'b0)) u_ovp (
    .clk(clk), .rst_n(rst_n), .flag_i(vdd_over_flag), .fault_o(ovp_fault));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              otp_q <= 1'b0;
    else if (temp_hot_flag)  otp_q <= 1'b1;
    else if (temp_cool_flag) otp_q <= 1'b0;
  end

  assign drive_disable = scp_fault | pin_short_fault | pin_open_fault | ovp_fault | otp_q;

  // R9
  otp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    temp_hot_flag |=> drive_disable);

  // R9
  otp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (otp_q && !temp_cool_flag) |=> otp_q);

  // R5
  scp_need_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_q |-> !scp_fault);

  // R2
  first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_q |-> !rise_evt);
endmodule

// File: tb/test_fb_fault_supervisor.sv
module test_fb_fault_supervisor;
  localparam int SW = 12, LVL = 270, SHR = 100, SCPT = 40, PINT = 10, OVPT = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fb_valid = 1'b0;
  logic [SW-1:0] fb_sample = '0;
  logic rp_low_flag = 1'b0, rp_high_flag = 1'b0, vdd_over_flag = 1'b0;
  logic temp_hot_flag = 1'b0, temp_cool_flag = 1'b0;
  logic shrink_req, drive_disable;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fb_fault_supervisor #(.SAMPLE_W(SW), .SCP_LEVEL(LVL), .SHRINK_TICKS(SHR),
    .SCP_TICKS(SCPT), .PIN_TICKS(PINT), .OVP_TICKS(OVPT)) i_fb_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .fb_valid(fb_valid), .fb_sample(fb_sample),
    .rp_low_flag(rp_low_flag), .rp_high_flag(rp_high_flag),
    .vdd_over_flag(vdd_over_flag), .temp_hot_flag(temp_hot_flag),
    .temp_cool_flag(temp_cool_flag), .shrink_req(shrink_req),
    .drive_disable(drive_disable));

  function automatic bit exp_rise(int cur, int prv);
    return (cur * 5) > (prv * 6);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; fb_valid = 1'b0; fb_sample = '0;
    rp_low_flag = 0; rp_high_flag = 0; vdd_over_flag = 0;
    temp_hot_flag = 0; temp_cool_flag = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic word(int v);
    fb_valid = 1'b1; fb_sample = SW'(v);
    step(1);
    fb_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 shrink after reset", shrink_req, 1'b0);
    chk("R1 disable after reset", drive_disable, 1'b0);

    // R2: first word never triggers, >20% step opens a window of SHR cycles
    word(500);
    chk("R2 first word", shrink_req, 1'b0);
    word(601);
    chk("R2 window open", shrink_req, 1'b1);
    step(SHR - 1);
    chk("R2 window last cycle", shrink_req, 1'b1);
    step(1);
    chk("R2 window closed", shrink_req, 1'b0);

    // R3: exactly 20 percent and a fall do not trigger
    word(500); word(600);
    chk("R3 exact 20pct", shrink_req, 1'b0);
    word(400);
    chk("R3 falling word", shrink_req, 1'b0);

    // R4: restart of an open window
    word(800);
    chk("R4 first rise", shrink_req, 1'b1);
    step(50);
    word(1000);
    chk("R4 second rise", shrink_req, 1'b1);
    step(SHR - 1);
    chk("R4 extended window", shrink_req, 1'b1);
    step(1);
    chk("R4 window end", shrink_req, 1'b0);

    // R5: short debounce, interruption, latch
    do_reset();
    step(SCPT + 5);
    chk("R5 no word no short", drive_disable, 1'b0);
    word(100); step(20); word(500); word(100);
    step(SCPT - 1);
    chk("R5 interrupted count", drive_disable, 1'b0);
    step(1);
    chk("R5 short set", drive_disable, 1'b1);
    word(900); step(5);
    chk("R5 short latched", drive_disable, 1'b1);

    // R6: pin short debounce with a gap, then latch
    do_reset();
    rp_low_flag = 1; step(5); rp_low_flag = 0; step(1); rp_low_flag = 1;
    step(PINT - 1);
    chk("R6 before debounce", drive_disable, 1'b0);
    step(1);
    chk("R6 pin short set", drive_disable, 1'b1);
    rp_low_flag = 0; step(3);
    chk("R6 pin short latched", drive_disable, 1'b1);

    // R7: pin open
    do_reset();
    rp_high_flag = 1; step(PINT - 1);
    chk("R7 before debounce", drive_disable, 1'b0);
    step(1);
    chk("R7 pin open set", drive_disable, 1'b1);
    rp_high_flag = 0; step(3);
    chk("R7 pin open latched", drive_disable, 1'b1);

    // R8: over-voltage debounce and release
    do_reset();
    vdd_over_flag = 1; step(OVPT - 1);
    chk("R8 before debounce", drive_disable, 1'b0);
    step(1);
    chk("R8 ovp set", drive_disable, 1'b1);
    vdd_over_flag = 0; step(1);
    chk("R8 ovp released", drive_disable, 1'b0);

    // R9: thermal set, hold, release; hot wins over cool
    do_reset();
    temp_hot_flag = 1; temp_cool_flag = 1; step(1);
    chk("R9 hot sets", drive_disable, 1'b1);
    temp_hot_flag = 0; temp_cool_flag = 0; step(5);
    chk("R9 hold", drive_disable, 1'b1);
    temp_cool_flag = 1; step(1);
    chk("R9 cool clears", drive_disable, 1'b0);

    // R2, R3, R4: random words against a bench model
    do_reset();
    begin
      int seed_dummy;
      int prv, cnt;
      bit have;
      seed_dummy = $urandom(32'd2024);
      have = 0; prv = 0; cnt = 0;
      for (int c = 0; c < 3000; c++) begin
        bit v;
        int w;
        v = ($urandom % 4) == 0;
        w = 300 + int'($urandom % 700);
        fb_valid = v; fb_sample = SW'(w);
        if (v && have && exp_rise(w, prv)) cnt = SHR;
        else if (cnt > 0) cnt--;
        if (v) begin have = 1; prv = w; end
        step(1);
        chk("R2 R3 R4 random window", shrink_req, cnt != 0);
      end
      fb_valid = 0;
      chk("R5 random no fault", drive_disable, 1'b0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule